// File: doc/BRIEF.md
# Byte-Serial Write Data Packer

This block sits between a narrow 8-bit multiplexed address/data port and a wider downstream peripheral. During a write, the upstream side places one data byte at a time on the byte bus and marks each one with a rising edge on a separate capture strobe. The packer collects these bytes and assembles them into a 16-bit or 32-bit word. When the word is complete, it presents the word to the downstream device together with a single-cycle valid strobe.

Two control inputs qualify every byte: the active-low output enable and the direction signal. A byte is taken only when output enable is low and direction reads as write. The capture strobe arrives from a slower domain, so it is synchronised to the system clock, and a registered detector finds its rising edges. Bytes fill the word from the most significant lane downward. If the qualifying condition is lost partway through a word, or the width mode changes, the partial word is dropped.

Top module: `wpack_top`

## Requirements
- R1: A synchronous active-low reset clears `byte_cnt` to 0, `word_out` to 0 and `word_vld` to 0, including when it arrives in the middle of a word.
- R2: With `wide_sel` = 1 (32-bit mode), four qualified capture edges make one word. The first byte lands in bits 31:24, the second in 23:16, the third in 15:8 and the fourth in 7:0.
- R3: With `wide_sel` = 0 (16-bit mode), two qualified capture edges make one word. The first byte lands in bits 15:8 and the second in 7:0, and bits 31:16 are 0. In this mode `byte_cnt` never exceeds 1.
- R4: Each rising edge of `cap_pulse` takes exactly one byte, however long the strobe stays high. `byte_cnt` reports how many bytes of the current word are held.
- R5: A capture edge seen while `oe_n` = 1 or `dir` = 0 takes no byte: `byte_cnt`, `word_out` and `word_vld` are unaffected.
- R6: If `oe_n` goes to 1 or `dir` goes to 0 while a word is partly filled, the partial word is discarded and `byte_cnt` returns to 0. A change of `wide_sel` does the same. The next word is then built from fresh bytes only.
- R7: When the last byte of a word is taken, `word_vld` is high for exactly one cycle and `byte_cnt` returns to 0. `word_out` then holds its value until the next word completes.
- R8: With the default two synchroniser stages, `word_vld` rises at the third rising clock edge after the final `cap_pulse` is first sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| byte_in | input | 8 | Write byte from the narrow bus |
| cap_pulse | input | 1 | Capture strobe; its rising edge marks a byte |
| oe_n | input | 1 | Output enable, active low; must be 0 to capture |
| dir | input | 1 | Direction; 1 means write, required to capture |
| wide_sel | input | 1 | 1 = 32-bit word, 0 = 16-bit word |
| word_out | output | 32 | Last completed word |
| word_vld | output | 1 | One-cycle strobe when `word_out` is updated |
| byte_cnt | output | 2 | Bytes held in the current partial word |

## Verification
The bench uses the default parameters: 8-bit bytes, a 32-bit word (four lanes) and two synchroniser stages. This gives both the four-byte and the two-byte word lengths, and it fixes the capture latency at three clock edges, so the bench can check the exact cycle of the valid strobe. Each byte is sent as a long strobe pulse. This exposes any repeated capture on a held-high strobe. Directed cases cover mid-word aborts caused by dropped qualification, a change of mode and reset.

// File: rtl/wpack_pkg.sv
// Package: shared types for the byte-serial write packer.
// Assumes nothing beyond the standard language.
package wpack_pkg;
    // Word width mode selected by the wide_sel input
    typedef enum logic {
        MODE_HALF = 1'b0,   // word built from half the lanes
        MODE_FULL = 1'b1    // word built from all lanes
    } wpack_mode_e;
endpackage

// File: rtl/wpack_edge.sv
// Module: wpack_edge
// Brings the asynchronous capture strobe into the clock domain through
// SYNC_STAGES flops and flags each rising edge for one cycle.
// Assumes the strobe stays high and low for at least two clocks each.
module wpack_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_in,
    output logic rise
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // Purpose: shift the strobe through the synchroniser and keep the last level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], strobe_in};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    // Purpose: rising edge = synchronised level high, previous level low
    always_comb rise = sync_q[SYNC_STAGES-1] & ~prev_q;
endmodule

// File: rtl/wpack_seq.sv
// Module: wpack_seq
// Counts qualified bytes of the current word, picks the lane for each
// byte (most significant first), and decides completion and abort.
// Assumes LANES is an even number of at least 2.
module wpack_seq
    import wpack_pkg::*;
#(
    parameter int LANES = 4,
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    input  logic             oe_n,
    input  logic             dir,
    input  wpack_mode_e      mode,
    output logic             take,
    output logic             done,
    output logic             clear,
    output logic [CNT_W-1:0] lane_sel,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] LAST_FULL = CNT_W'(LANES - 1);
    localparam logic [CNT_W-1:0] LAST_HALF = CNT_W'(LANES / 2 - 1);

    wpack_mode_e      mode_q;
    logic             qual;
    logic [CNT_W-1:0] last;

    // Purpose: decode qualification, abort, capture and lane choice
    always_comb begin
        qual     = !oe_n && dir;
        clear    = !qual || (mode != mode_q);
        last     = (mode == MODE_FULL) ? LAST_FULL : LAST_HALF;
        take     = rise && !clear;
        done     = take && (cnt == last);
        lane_sel = last - cnt;
    end

    // Purpose: advance, wrap or drop the byte count; remember the mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            mode_q <= MODE_FULL;
        end else begin
            mode_q <= mode;
            if (clear || done) begin
                cnt <= '0;
            end else if (take) begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/wpack_lanes.sv
// Module: wpack_lanes
// Holds one byte register per lane of the partial word, merges the
// incoming byte, and loads the finished word with a one-cycle strobe.
// Assumes take/done/clear come from wpack_seq in the same cycle.
module wpack_lanes #(
    parameter int BYTE_W = 8,
    parameter int LANES  = 4,
    parameter int CNT_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [BYTE_W-1:0]       byte_in,
    input  logic                    take,
    input  logic                    done,
    input  logic                    clear,
    input  logic [CNT_W-1:0]        lane_sel,
    output logic [LANES*BYTE_W-1:0] word_out,
    output logic                    word_vld
);
    logic [BYTE_W-1:0]       lane_q [LANES];
    logic [LANES*BYTE_W-1:0] word_nxt;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic hit;
        // Purpose: flag that this lane receives the incoming byte
        always_comb hit = take && (lane_sel == CNT_W'(i));

        // Purpose: store this lane's byte; empty it on abort or completion
        always_ff @(posedge clk) begin
            if (!rst_n || clear || done) begin
                lane_q[i] <= '0;
            end else if (hit) begin
                lane_q[i] <= byte_in;
            end
        end

        // Purpose: lane value including a byte arriving this cycle
        always_comb word_nxt[i*BYTE_W +: BYTE_W] = hit ? byte_in : lane_q[i];
    end

    // Purpose: publish the finished word and raise the valid strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_out <= '0;
            word_vld <= 1'b0;
        end else begin
            word_vld <= done;
            if (done) begin
                word_out <= word_nxt;
            end
        end
    end
endmodule

// File: rtl/wpack_top.sv
// Module: wpack_top
// Packs qualified bytes from a narrow write bus into a 16- or 32-bit
// word (selectable) for a wide downstream device.
// Assumes byte_in, oe_n and dir are stable around each capture edge.
module wpack_top
    import wpack_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int WORD_W      = 32,
    parameter int SYNC_STAGES = 2,
    localparam int LANES      = WORD_W / BYTE_W,
    localparam int CNT_W      = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              cap_pulse,
    input  logic              oe_n,
    input  logic              dir,
    input  logic              wide_sel,
    output logic [WORD_W-1:0] word_out,
    output logic              word_vld,
    output logic [CNT_W-1:0]  byte_cnt
);
    logic             rise;
    logic             take;
    logic             done;
    logic             clear;
    logic [CNT_W-1:0] lane_sel;
    wpack_mode_e      mode;

    // Purpose: map the width select pin onto the mode type
    always_comb mode = wpack_mode_e'(wide_sel);

    wpack_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe_in (cap_pulse),
        .rise      (rise)
    );

    wpack_seq #(.LANES(LANES), .CNT_W(CNT_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise     (rise),
        .oe_n     (oe_n),
        .dir      (dir),
        .mode     (mode),
        .take     (take),
        .done     (done),
        .clear    (clear),
        .lane_sel (lane_sel),
        .cnt      (byte_cnt)
    );

    wpack_lanes #(.BYTE_W(BYTE_W), .LANES(LANES), .CNT_W(CNT_W)) u_lanes (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_in  (byte_in),
        .take     (take),
        .done     (done),
        .clear    (clear),
        .lane_sel (lane_sel),
        .word_out (word_out),
        .word_vld (word_vld)
    );
endmodule

// File: rtl/wpack_checks.sv
// Module: wpack_checks
// Port-level properties of wpack_top, attached by bind below.
// Assumes the same BYTE_W and WORD_W as the bound instance.
module wpack_checks #(
    parameter int BYTE_W = 8,
    parameter int WORD_W = 32,
    localparam int LANES = WORD_W / BYTE_W,
    localparam int CNT_W = $clog2(LANES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              oe_n,
    input logic              dir,
    input logic              wide_sel,
    input logic [WORD_W-1:0] word_out,
    input logic              word_vld,
    input logic [CNT_W-1:0]  byte_cnt
);
    localparam logic [CNT_W-1:0] HALF_MAX = CNT_W'(LANES / 2 - 1);

    p_vld_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |=> !word_vld);

    p_cnt_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |-> (byte_cnt == '0));

    p_word_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !word_vld |-> $stable(word_out));

    p_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_n || !dir) |=> (byte_cnt == '0));

    p_half_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide_sel && $past(!wide_sel)) |-> (byte_cnt <= HALF_MAX));

    p_vld_qual_r5: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |-> $past(!oe_n && dir));
endmodule

bind wpack_top wpack_checks #(.BYTE_W(BYTE_W), .WORD_W(WORD_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .oe_n     (oe_n),
    .dir      (dir),
    .wide_sel (wide_sel),
    .word_out (word_out),
    .word_vld (word_vld),
    .byte_cnt (byte_cnt)
);

// File: tb/wpack_top_test.sv
module wpack_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  byte_in = '0;
    logic        cap_pulse = 1'b0;
    logic        oe_n = 1'b0;
    logic        dir = 1'b1;
    logic        wide_sel = 1'b1;
    logic [31:0] word_out;
    logic        word_vld;
    logic [1:0]  byte_cnt;

    int checks = 0;
    int errors = 0;
    int vld_hits = 0;
    int vld_k = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    wpack_top uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_in   (byte_in),
        .cap_pulse (cap_pulse),
        .oe_n      (oe_n),
        .dir       (dir),
        .wide_sel  (wide_sel),
        .word_out  (word_out),
        .word_vld  (word_vld),
        .byte_cnt  (byte_cnt)
    );

    // vector: {wide, byte0..byte3 (byte0 first), expected word}
    localparam logic [64:0] VEC [6] = '{
        {1'b1, 32'h12345678, 32'h12345678},
        {1'b1, 32'hA55AFF00, 32'hA55AFF00},
        {1'b0, 32'hBEEF0000, 32'h0000BEEF},
        {1'b0, 32'h01800000, 32'h00000180},
        {1'b1, 32'hDEADBEEF, 32'hDEADBEEF},
        {1'b0, 32'hC33C0000, 32'h0000C33C}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // One strobe: high 4 cycles, low 4 cycles; counts valid pulses seen
    task automatic send(input logic [7:0] b);
        byte_in   = b;
        cap_pulse = 1'b1;
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            if (word_vld) begin
                vld_hits++;
                if (vld_k == 0) vld_k = k;
            end
        end
        cap_pulse = 1'b0;
        for (int k = 5; k <= 8; k++) begin
            @(negedge clk);
            if (word_vld) begin
                vld_hits++;
                if (vld_k == 0) vld_k = k;
            end
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            summary();
        end
    end

    initial begin
        logic [31:0] held;
        idle(3);
        // R1: reset state
        chk(byte_cnt == 2'd0, "R1 reset cnt", 32'(byte_cnt), 0);
        chk(word_out == 32'd0 && !word_vld, "R1 reset word", word_out, 0);
        rst_n = 1'b1;
        idle(2);

        // Table walk: R2 / R3 words, R7 strobe, R8 latency
        foreach (VEC[v]) begin
            wide_sel = VEC[v][64];
            idle(3);
            vld_hits = 0;
            for (int j = 0; j < (VEC[v][64] ? 4 : 2); j++) begin
                vld_k = 0;
                send(VEC[v][63 - 8*j -: 8]);
            end
            chk(word_out === VEC[v][31:0], VEC[v][64] ? "R2 word" : "R3 word",
                word_out, VEC[v][31:0]);
            chk(vld_hits == 1, "R7 one strobe", 32'(vld_hits), 1);
            chk(vld_k == 3, "R8 latency", 32'(vld_k), 3);
            chk(byte_cnt == 2'd0, "R7 cnt wrap", 32'(byte_cnt), 0);
        end

        // R7: word_out holds after strobe
        held = word_out;
        idle(10);
        chk(word_out === held, "R7 hold", word_out, held);

        // R4: one byte per long edge, count visible
        wide_sel = 1'b1;
        idle(3);
        send(8'h11);
        chk(byte_cnt == 2'd1, "R4 cnt1", 32'(byte_cnt), 1);
        send(8'h22);
        chk(byte_cnt == 2'd2, "R4 cnt2", 32'(byte_cnt), 2);
        send(8'h33);
        chk(byte_cnt == 2'd3, "R4 cnt3", 32'(byte_cnt), 3);

        // R6: qualification drop discards the partial word
        oe_n = 1'b1;
        idle(2);
        chk(byte_cnt == 2'd0, "R6 abort cnt", 32'(byte_cnt), 0);
        oe_n = 1'b0;
        idle(2);
        vld_hits = 0;
        send(8'h9A); send(8'hBC); send(8'hDE); send(8'hF0);
        chk(word_out === 32'h9ABCDEF0, "R6 fresh word", word_out, 32'h9ABCDEF0);

        // R5: edges with oe_n high or dir low are ignored
        held = word_out;
        vld_hits = 0;
        oe_n = 1'b1;
        send(8'h55);
        chk(byte_cnt == 2'd0, "R5 oe_n cnt", 32'(byte_cnt), 0);
        oe_n = 1'b0;
        dir  = 1'b0;
        send(8'h66);
        chk(byte_cnt == 2'd0, "R5 dir cnt", 32'(byte_cnt), 0);
        chk(vld_hits == 0 && word_out === held, "R5 no word", word_out, held);
        dir = 1'b1;
        idle(2);

        // R6: width change mid-word discards; R3 bound in half mode
        send(8'hAA); send(8'hBB);
        wide_sel = 1'b0;
        idle(2);
        chk(byte_cnt == 2'd0, "R6 mode abort", 32'(byte_cnt), 0);
        send(8'h12);
        chk(byte_cnt == 2'd1, "R3 half cnt", 32'(byte_cnt), 1);
        send(8'h34);
        chk(word_out === 32'h00001234, "R3 after switch", word_out, 32'h00001234);

        // R1: reset in mid-word
        send(8'h77);
        rst_n = 1'b0;
        idle(2);
        chk(byte_cnt == 2'd0 && !word_vld, "R1 mid reset cnt", 32'(byte_cnt), 0);
        chk(word_out === 32'd0, "R1 mid reset word", word_out, 0);
        rst_n = 1'b1;
        idle(2);

        finished = 1'b1;
        summary();
    end
endmodule